// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes accepted receive frames as a byte stream and lays them into a circular packet store in local memory. The store is cut into 256-byte pages. Two page registers, a first page and an exclusive end page, bound the ring. The block holds a current-page pointer that marks where the next frame goes. Before it takes a frame, it measures the free room between that pointer and a host-owned read boundary. It refuses the frame unless a worst-case frame, plus its link header, would fit.

An accepted frame's payload goes to the first page from byte offset 4 onward and wraps from the end page back to the first page. Frames under the minimum size are padded with zero bytes. Only after the last payload or pad byte is stored does the block write a 4-byte link header into the first four bytes of the frame's first page. It then moves the current page past the frame and raises a sticky receive flag. A frame that is aborted or that runs over the size limit leaves no header, no pointer movement and no flag.

The host sets the ring bounds and the boundary, may load the current page while the block is idle, and clears the flag. Address filtering and readback of the stored data belong to other blocks.

Top module: `rxr_ring_writer`

## Requirements
- R1: Page p covers byte addresses p*256 to p*256+255. The end page is exclusive. The payload of a frame starts at byte 4 of the current page.
- R2: When a frame starts, the free room is measured in pages, each page counting 256 bytes. If current < boundary the room is (boundary - current). Otherwise it is (end - first) - (current - boundary). If the room is under 1518 bytes, the whole frame is dropped: nothing is written, and neither the current page nor the flag changes.
- R3: While `halt` is 1, a frame start is refused the same way as in R2.
- R4: A frame of fewer than 60 bytes is followed in memory by zero bytes up to 60 stored bytes. The stored length counts those pad bytes.
- R5: The header is written at byte offsets 0, 1, 2 and 3 of the frame's first page, in that order: the status byte, the next page, then the low and the high byte of (stored length + 4). The header is written only after the last payload or pad byte.
- R6: The next page is current + ceil((stored length + 8) / 256). If that value is equal to or beyond the end page, (end - first) is subtracted from it.
- R7: A payload or pad byte that would land on the end page's first address goes to the first page's first address instead.
- R8: The status byte is 0x01. Bit 5 (0x20) is also set when bit 0 of the frame's first byte is 1.
- R9: At the cycle the header's last byte is written, `cur_pg` takes the next-page value and `irq_flag` becomes 1. Otherwise `cur_pg` changes only through a `cur_ld` load.
- R10: `irq_flag` stays 1 until `irq_clr` is 1 at a clock edge. If a clear and a frame completion fall on the same edge, the flag ends at 1.
- R11: `fr_abort` during a frame ends the frame with no header, no flag and no change of `cur_pg`.
- R12: A frame longer than 1514 bytes is discarded like an aborted one when its 1515th byte arrives.
- R13: While the block pads or writes a header, the frame input is ignored. A frame whose start arrives then is not stored, and none of its bytes are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Receiver halted; frame starts are refused |
| start_pg | input | PG_W | First page of the ring |
| stop_pg | input | PG_W | End page of the ring (exclusive) |
| bnd_pg | input | PG_W | Host read boundary page |
| cur_ld | input | 1 | Load `cur_ld_pg` into the current page |
| cur_ld_pg | input | PG_W | Value for a current-page load |
| fr_sof | input | 1 | First byte of a frame (with `fr_valid`) |
| fr_valid | input | 1 | `fr_data` carries a frame byte |
| fr_eof | input | 1 | Last byte of a frame (with `fr_valid`) |
| fr_abort | input | 1 | Abandon the frame in progress |
| fr_data | input | 8 | Frame byte |
| irq_clr | input | 1 | Clear the receive flag |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | PG_W+8 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| cur_pg | output | PG_W | Current page pointer |
| irq_flag | output | 1 | Sticky receive-complete flag |
| busy | output | 1 | A frame is being taken, padded, dropped or headed |

## Verification
Two events can meet on one clock edge: the host's flag clear and the completion of a frame, which sets the flag. The bench works out the completion edge from the last frame byte: the pad byte count plus four header cycles. It drives `irq_clr` for exactly that edge while the flag is already 1, and then expects the flag to read 1. A later lone clear must take it to 0. A third run sends a second frame start during the first frame's pad phase, and expects the current page to move by exactly one frame.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DATA = 3'd1,
        S_PAD  = 3'd2,
        S_HDR  = 3'd3,
        S_DROP = 3'd4
    } rxr_state_e;

    localparam int HDR_BYTES  = 4;
    localparam int FCS_BYTES  = 4;
    localparam int PAGE_SHIFT = 8;

    localparam logic [7:0] ST_GOOD  = 8'h01;
    localparam logic [7:0] ST_GROUP = 8'h20;

endpackage

// File: rtl/rxr_space.sv
module rxr_space #(
    parameter int PG_W     = 8,
    parameter int MIN_FREE = 1518
) (
    input  logic [PG_W-1:0] cur,
    input  logic [PG_W-1:0] bnd,
    input  logic [PG_W-1:0] first,
    input  logic [PG_W-1:0] last,
    output logic            fits
);
    localparam int SW = PG_W + 2;
    localparam int BW = SW + 8;
    localparam logic signed [BW-1:0] MIN_B = BW'(MIN_FREE);

    logic signed [SW-1:0] c_s, b_s, f_s, l_s, room_pg;
    logic signed [BW-1:0] room_b;

    always_comb begin
        c_s = $signed({2'b00, cur});
        b_s = $signed({2'b00, bnd});
        f_s = $signed({2'b00, first});
        l_s = $signed({2'b00, last});
        if (c_s < b_s) begin
            room_pg = b_s - c_s;
        end else begin
            room_pg = (l_s - f_s) - (c_s - b_s);
        end
        room_b = $signed({room_pg, 8'h00});
        fits   = (room_b >= MIN_B);
    end
endmodule

// File: rtl/rxr_nextpg.sv
module rxr_nextpg
    import rxr_pkg::*;
#(
    parameter int PG_W  = 8,
    parameter int LEN_W = 11
) (
    input  logic [PG_W-1:0]  base,
    input  logic [LEN_W-1:0] len,
    input  logic [PG_W-1:0]  first,
    input  logic [PG_W-1:0]  last,
    output logic [PG_W-1:0]  next
);
    localparam int TW = LEN_W + 1;
    localparam int EW = PG_W + 2;

    logic [TW-1:0] span_b;
    logic [EW-1:0] pages, sum, ring, fold;
    logic          unused_bits;

    always_comb begin
        span_b = TW'(len) + TW'(HDR_BYTES + FCS_BYTES + 255);
        pages  = EW'(span_b[TW-1:PAGE_SHIFT]);
        sum    = {2'b00, base} + pages;
        ring   = {2'b00, last} - {2'b00, first};
        fold   = (sum >= {2'b00, last}) ? (sum - ring) : sum;
        next   = fold[PG_W-1:0];
    end

    assign unused_bits = ^{span_b[PAGE_SHIFT-1:0], fold[EW-1:PG_W]};
endmodule

// File: rtl/rxr_wrap.sv
module rxr_wrap #(
    parameter int PG_W = 8
) (
    input  logic [PG_W+7:0] addr,
    input  logic [PG_W-1:0] first,
    input  logic [PG_W-1:0] last,
    output logic [PG_W+7:0] addr_nx
);
    logic [PG_W+7:0] step;

    always_comb begin
        step    = addr + 1'b1;
        addr_nx = (step == {last, 8'h00}) ? {first, 8'h00} : step;
    end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int PG_W      = 8,
    parameter int LEN_W     = 11,
    parameter int MIN_FRAME = 60,
    parameter int MAX_FRAME = 1514
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic [PG_W-1:0]   start_pg,
    input  logic [PG_W-1:0]   stop_pg,
    input  logic [PG_W-1:0]   bnd_pg,
    input  logic              cur_ld,
    input  logic [PG_W-1:0]   cur_ld_pg,
    input  logic              fr_sof,
    input  logic              fr_valid,
    input  logic              fr_eof,
    input  logic              fr_abort,
    input  logic [7:0]        fr_data,
    input  logic              irq_clr,
    output logic              mem_we,
    output logic [PG_W+7:0]   mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [PG_W-1:0]   cur_pg,
    output logic              irq_flag,
    output logic              busy
);
    localparam int ADDR_W   = PG_W + 8;
    localparam int MIN_FREE = MAX_FRAME + HDR_BYTES;
    localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_FRAME);
    localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

    typedef struct packed {
        rxr_state_e        st;
        logic [ADDR_W-1:0] wptr;
        logic [LEN_W-1:0]  len;
        logic [PG_W-1:0]   base;
        logic              grp;
        logic [PG_W-1:0]   cur;
        logic              irq;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic [1:0]        hidx;
    } regs_t;

    regs_t r_d, r_q;

    logic              room_ok;
    logic [ADDR_W-1:0] wptr_nx;
    logic [PG_W-1:0]   next_pg;
    logic [15:0]       stored_tot;
    logic [7:0]        hdr_byte;
    logic              done;

    rxr_space #(.PG_W(PG_W), .MIN_FREE(MIN_FREE)) u_space (
        .cur   (r_q.cur),
        .bnd   (bnd_pg),
        .first (start_pg),
        .last  (stop_pg),
        .fits  (room_ok)
    );

    rxr_wrap #(.PG_W(PG_W)) u_wrap (
        .addr    (r_q.wptr),
        .first   (start_pg),
        .last    (stop_pg),
        .addr_nx (wptr_nx)
    );

    rxr_nextpg #(.PG_W(PG_W), .LEN_W(LEN_W)) u_next (
        .base  (r_q.base),
        .len   (r_q.len),
        .first (start_pg),
        .last  (stop_pg),
        .next  (next_pg)
    );

    // header byte selected by position within the link header
    always_comb begin
        stored_tot = 16'(r_q.len) + 16'(HDR_BYTES);
        case (r_q.hidx)
            2'd0:    hdr_byte = r_q.grp ? (ST_GOOD | ST_GROUP) : ST_GOOD;
            2'd1:    hdr_byte = 8'(next_pg);
            2'd2:    hdr_byte = stored_tot[7:0];
            default: hdr_byte = stored_tot[15:8];
        endcase
    end

    always_comb begin
        r_d       = r_q;
        r_d.we    = 1'b0;
        r_d.wdata = 8'h00;
        done      = 1'b0;

        case (r_q.st)
            S_IDLE: begin
                if (fr_valid && fr_sof) begin
                    if (room_ok && !halt) begin
                        r_d.we    = 1'b1;
                        r_d.addr  = {r_q.cur, 8'(HDR_BYTES)};
                        r_d.wdata = fr_data;
                        r_d.wptr  = {r_q.cur, 8'(HDR_BYTES + 1)};
                        r_d.len   = ONE_L;
                        r_d.base  = r_q.cur;
                        r_d.grp   = fr_data[0];
                        r_d.hidx  = 2'd0;
                        if (fr_eof) begin
                            r_d.st = (ONE_L < MIN_L) ? S_PAD : S_HDR;
                        end else begin
                            r_d.st = S_DATA;
                        end
                    end else if (!fr_eof) begin
                        r_d.st = S_DROP;
                    end
                end
            end

            S_DATA: begin
                if (fr_abort) begin
                    r_d.st = S_IDLE;
                end else if (fr_valid) begin
                    if (r_q.len == MAX_L) begin
                        r_d.st = fr_eof ? S_IDLE : S_DROP;
                    end else begin
                        r_d.we    = 1'b1;
                        r_d.addr  = r_q.wptr;
                        r_d.wdata = fr_data;
                        r_d.wptr  = wptr_nx;
                        r_d.len   = r_q.len + ONE_L;
                        if (fr_eof) begin
                            r_d.st = ((r_q.len + ONE_L) < MIN_L) ? S_PAD : S_HDR;
                        end
                    end
                end
            end

            S_PAD: begin
                r_d.we    = 1'b1;
                r_d.addr  = r_q.wptr;
                r_d.wdata = 8'h00;
                r_d.wptr  = wptr_nx;
                r_d.len   = r_q.len + ONE_L;
                if ((r_q.len + ONE_L) == MIN_L) begin
                    r_d.st = S_HDR;
                end
            end

            S_HDR: begin
                r_d.we    = 1'b1;
                r_d.addr  = {r_q.base, 6'd0, r_q.hidx};
                r_d.wdata = hdr_byte;
                r_d.hidx  = r_q.hidx + 2'd1;
                if (r_q.hidx == 2'd3) begin
                    done   = 1'b1;
                    r_d.st = S_IDLE;
                end
            end

            S_DROP: begin
                if (fr_abort || (fr_valid && fr_eof)) begin
                    r_d.st = S_IDLE;
                end
            end

            default: r_d.st = S_IDLE;
        endcase

        if (done) begin
            r_d.cur = next_pg;
        end else if (cur_ld) begin
            r_d.cur = cur_ld_pg;
        end

        r_d.irq = (r_q.irq & ~irq_clr) | done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q    <= r_d;
        end
    end

    assign mem_we    = r_q.we;
    assign mem_addr  = r_q.addr;
    assign mem_wdata = r_q.wdata;
    assign cur_pg    = r_q.cur;
    assign irq_flag  = r_q.irq;
    assign busy      = (r_q.st != S_IDLE);

endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
    parameter int PG_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            halt,
    input logic [PG_W-1:0] start_pg,
    input logic [PG_W-1:0] stop_pg,
    input logic            cur_ld,
    input logic            fr_sof,
    input logic            fr_valid,
    input logic            irq_clr,
    input logic            mem_we,
    input logic [PG_W+7:0] mem_addr,
    input logic [PG_W-1:0] cur_pg,
    input logic            irq_flag,
    input logic            busy
);
    AST_WR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && (start_pg < stop_pg)) |->
            ((mem_addr >= {start_pg, 8'h00}) && (mem_addr < {stop_pg, 8'h00}))); // R7

    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && halt && fr_valid && fr_sof) |=> !mem_we); // R3

    AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy || $past(busy))); // R5

    AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cur_ld) && !$past(busy)) |-> $stable(cur_pg)); // R9

    AST_FLAG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(busy)); // R9

    AST_FLAG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> $past(irq_clr)); // R10
endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(.PG_W(PG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .start_pg (start_pg),
    .stop_pg  (stop_pg),
    .cur_ld   (cur_ld),
    .fr_sof   (fr_sof),
    .fr_valid (fr_valid),
    .irq_clr  (irq_clr),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .cur_pg   (cur_pg),
    .irq_flag (irq_flag),
    .busy     (busy)
);

// File: tb/sim_rxr_ring_writer.sv
module sim_rxr_ring_writer;
    localparam int FIRST = 2;
    localparam int LAST  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic [7:0]  start_pg = 8'(FIRST);
    logic [7:0]  stop_pg  = 8'(LAST);
    logic [7:0]  bnd_pg = 8'h00;
    logic        cur_ld = 1'b0;
    logic [7:0]  cur_ld_pg = 8'h00;
    logic        fr_sof = 1'b0, fr_valid = 1'b0, fr_eof = 1'b0, fr_abort = 1'b0;
    logic [7:0]  fr_data = 8'h00;
    logic        irq_clr = 1'b0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_pg;
    logic        irq_flag;
    logic        busy;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    bit done_flag = 0;
    logic [7:0] bmem [0:8191];
    logic [7:0] fb   [0:2047];

    always #4 clk = ~clk;

    rxr_ring_writer u0 (
        .clk(clk), .rst_n(rst_n), .halt(halt), .start_pg(start_pg),
        .stop_pg(stop_pg), .bnd_pg(bnd_pg), .cur_ld(cur_ld), .cur_ld_pg(cur_ld_pg),
        .fr_sof(fr_sof), .fr_valid(fr_valid), .fr_eof(fr_eof), .fr_abort(fr_abort),
        .fr_data(fr_data), .irq_clr(irq_clr), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .cur_pg(cur_pg), .irq_flag(irq_flag), .busy(busy)
    );

    always @(negedge clk) begin
        if (mem_we) begin
            bmem[mem_addr[12:0]] = mem_wdata;
            wr_cnt++;
        end
    end

    function automatic int exp_next(input int base, input int plen);
        int n;
        n = base + (plen + 8 + 255) / 256;
        if (n >= LAST) n -= (LAST - FIRST);
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic fill(input int n, input bit grp);
        for (int i = 0; i < n; i++) fb[i] = 8'($urandom);
        fb[0][0] = grp;
    endtask

    task automatic send_frame(input int n, input int abort_at, input bit gaps, input int clr_k);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                @(negedge clk); fr_valid = 0; fr_sof = 0; fr_eof = 0;
            end
            @(negedge clk);
            if (i == abort_at) begin
                fr_valid = 0; fr_sof = 0; fr_eof = 0; fr_abort = 1;
                break;
            end
            fr_valid = 1; fr_sof = (i == 0); fr_eof = (i == n - 1); fr_data = fb[i];
        end
        @(negedge clk);
        fr_valid = 0; fr_sof = 0; fr_eof = 0; fr_abort = 0;
        if (clr_k > 0) begin
            repeat (clr_k - 1) @(negedge clk);
            irq_clr = 1;
            @(negedge clk);
            irq_clr = 0;
        end
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0;
    endtask

    task automatic load_cur(input int v);
        @(negedge clk); cur_ld = 1; cur_ld_pg = 8'(v);
        @(negedge clk); cur_ld = 0;
        chk(cur_pg == 8'(v), "R9 host load", cur_pg, v);
    endtask

    // compare stored header, payload with wrap, padding, pointer and flag
    task automatic check_frame(input int base, input int n);
        int plen, tot, nx, addr, bad;
        logic [7:0] st, ex;
        plen = (n < 60) ? 60 : n;
        tot  = plen + 4;
        nx   = exp_next(base, plen);
        st   = fb[0][0] ? 8'h21 : 8'h01;
        chk(bmem[base*256] == st, "R8 status byte", bmem[base*256], st);
        chk(bmem[base*256+1] == 8'(nx), "R6 next page in header", bmem[base*256+1], nx);
        chk({bmem[base*256+3], bmem[base*256+2]} == 16'(tot), "R5 length field",
            {bmem[base*256+3], bmem[base*256+2]}, tot);
        bad = 0;
        addr = base*256 + 4;
        for (int i = 0; i < plen; i++) begin
            ex = (i < n) ? fb[i] : 8'h00;
            if (bmem[addr] !== ex) bad++;
            addr++;
            if (addr == LAST*256) addr = FIRST*256;
        end
        chk(bad == 0, "R1 R4 R7 payload image", bad, 0);
        chk(cur_pg == 8'(nx), "R9 current page advance", cur_pg, nx);
        chk(irq_flag == 1'b1, "R9 flag set", irq_flag, 1);
    endtask

    task automatic expect_refused(input int cur0, input int wr0, input string req);
        chk(cur_pg == 8'(cur0), req, cur_pg, cur0);
        chk(wr_cnt == wr0, req, wr_cnt, wr0);
        chk(irq_flag == 1'b0, req, irq_flag, 0);
    endtask

    initial begin
        int seed, c0, w0, n;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(mem_we == 0 && busy == 0, "reset idle", {mem_we, busy}, 0);
        chk(cur_pg == 0 && irq_flag == 0, "reset pointer and flag", {cur_pg, irq_flag}, 0);

        // R3: halted receiver stores nothing
        load_cur(FIRST); bnd_pg = 8'(FIRST);
        halt = 1; fill(80, 0); w0 = wr_cnt;
        send_frame(80, -1, 0, 0); wait_idle();
        expect_refused(FIRST, w0, "R3 halt refuses");
        halt = 0;

        // R2: five pages free refused, six accepted
        load_cur(10); bnd_pg = 8'd15; fill(100, 0); w0 = wr_cnt;
        send_frame(100, -1, 0, 0); wait_idle();
        expect_refused(10, w0, "R2 room below limit");
        load_cur(28); bnd_pg = 8'd3; w0 = wr_cnt;
        send_frame(100, -1, 0, 0); wait_idle();
        expect_refused(28, w0, "R2 room with boundary behind");
        load_cur(10); bnd_pg = 8'd16; fill(1514, 1);
        send_frame(1514, -1, 0, 0); wait_idle();
        check_frame(10, 1514);
        clear_flag();
        chk(irq_flag == 0, "R10 clear", irq_flag, 0);

        // R4: short frame padded
        bnd_pg = cur_pg; fill(5, 0); c0 = cur_pg;
        send_frame(5, -1, 0, 0); wait_idle();
        check_frame(c0, 5);

        // R10: clear on the completion edge, flag already 1
        bnd_pg = cur_pg; fill(70, 1); c0 = cur_pg;
        send_frame(70, -1, 0, 4); wait_idle();
        chk(irq_flag == 1, "R10 set wins over clear", irq_flag, 1);
        check_frame(c0, 70);
        clear_flag();

        // R7 + R6: payload wraps, next page folds
        load_cur(31); bnd_pg = 8'd31; fill(300, 0);
        send_frame(300, -1, 1, 0); wait_idle();
        check_frame(31, 300);
        chk(cur_pg == 8'd3, "R6 fold past end", cur_pg, 3);
        clear_flag();
        load_cur(31); bnd_pg = 8'd31; fill(200, 1);
        send_frame(200, -1, 0, 0); wait_idle();
        chk(cur_pg == 8'(FIRST), "R6 next equal to end folds", cur_pg, FIRST);
        clear_flag();

        // R11: abort midway
        c0 = cur_pg; bnd_pg = cur_pg; fill(90, 0);
        send_frame(90, 40, 0, 0); wait_idle();
        chk(cur_pg == 8'(c0) && irq_flag == 0, "R11 abort leaves pointer",
            {cur_pg, irq_flag}, {8'(c0), 1'b0});

        // R12: oversize frame discarded
        send_frame(90, -1, 0, 0); wait_idle();
        check_frame(c0, 90);
        clear_flag();
        c0 = cur_pg; bnd_pg = cur_pg; fill(1515, 0);
        send_frame(1515, -1, 0, 0); wait_idle();
        chk(cur_pg == 8'(c0) && irq_flag == 0, "R12 oversize dropped",
            {cur_pg, irq_flag}, {8'(c0), 1'b0});

        // R13: start during padding ignored
        fill(20, 0);
        send_frame(10, -1, 0, 0);
        send_frame(20, -1, 0, 0); wait_idle();
        chk(cur_pg == 8'(exp_next(c0, 60)), "R13 second start ignored",
            cur_pg, exp_next(c0, 60));
        check_frame(c0, 10);
        clear_flag();

        // random frames
        for (int k = 0; k < 30; k++) begin
            c0 = cur_pg; bnd_pg = cur_pg;
            n = ($urandom % 8 == 0) ? 1514 : ($urandom % 200) + 1;
            fill(n, 1'($urandom));
            send_frame(n, -1, 1'($urandom), 0); wait_idle();
            check_frame(c0, n);
            clear_flag();
        end

        done_flag = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule